// File: doc/BRIEF.md
# UART Receive FIFO with Automatic Hardware Flow Control

This block sits between the receive shift register of one UART channel and the host-side read path. Each received character is pushed into the block as an 8-bit byte plus three error flags (parity, framing, break). The byte and its flags are stored together and come out together, in arrival order, at the head of the queue. The fill level is visible at all times. A receive interrupt is raised once the fill level reaches a programmable trigger.

The block also paces the link in both directions. On the receive side it drives an active-low request output. This output is released, which pauses the far-end transmitter, when the fill level climbs to the trigger plus a programmable hysteresis. It is asserted again, which lets the far end resume, when the level drains to the trigger minus that hysteresis. On the transmit side it watches an active-low clear input through a synchronizer and produces a permit for the local transmitter. A select bit picks either the request-to-send / clear-to-send pair or the terminal-ready / set-ready pair for both directions, and each direction has its own enable.

When the FIFO enable is low, the same storage behaves as a single holding register.

Top module: `uart_rx_fifo_fc`

## Requirements
- R1: Up to 64 characters are stored; `rd_data` and `rd_err` show the oldest stored byte and its flags, and a pop (`rd_en` while `rx_ready`=1) advances to the next one, so characters leave in the order they were written.
- R2: `fill_level` equals writes accepted minus pops; with `fifo_en`=1, `rx_irq` is 1 exactly when the level is nonzero and at least `trig_lvl`.
- R3: A write when the level equals the capacity, with no pop in the same cycle, is discarded and leaves the level unchanged; it sets `overrun`, which stays at 1 until a cycle with `stat_rd`=1 clears it (a new discard in that cycle wins).
- R4: A pop while empty leaves `fill_level` at 0, and `rd_data`/`rd_err` keep showing the last character popped (0 after reset).
- R5: With `fifo_en`=0 the capacity is one character and `rx_irq` is 1 whenever a character is held; any change of `fifo_en` empties the storage one cycle later.
- R6: When the selected request output is under automatic control, it goes high one cycle after the level becomes at least `trig_lvl`+`hyst`. It goes low one cycle after the level becomes at most `trig_lvl`-`hyst` (floor 0). Between those two levels it holds its value. The rising threshold takes priority.
- R7: Automatic request control is active only while `auto_req_en`=1 and the manual bit of the selected output is 1. Otherwise `rts_n` is the inverse of `man_rts` and `dtr_n` is the inverse of `man_dtr`.
- R8: `pair_sel`=0 selects `rts_n` (output) and `cts_n` (monitored input); `pair_sel`=1 selects `dtr_n` and `dsr_n`. The output that is not selected always follows the inverse of its manual bit, and the input that is not selected has no effect.
- R9: With `auto_clr_en`=1, `tx_allow` is 0 while the selected clear input, after a two-flop synchronizer, is 1, so it follows the pin two clock edges later. With `auto_clr_en`=0, `tx_allow` is 1.
- R10: After reset `fill_level`=0, `rx_ready`=0, `rx_irq`=0, `overrun`=0, `rd_data`=0 and `tx_allow`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fifo_en | input | 1 | 1: 64-entry queue, 0: single holding register |
| wr_valid | input | 1 | Push one received character |
| wr_data | input | 8 | Received byte |
| wr_err | input | 3 | Error flags of the received byte |
| rd_en | input | 1 | Pop the head character |
| rd_data | output | 8 | Head byte, or last popped byte when empty |
| rd_err | output | 3 | Error flags of the head byte |
| rx_ready | output | 1 | At least one character stored |
| fill_level | output | 7 | Number of stored characters |
| rx_irq | output | 1 | Receive-data interrupt |
| stat_rd | input | 1 | Status read strobe, clears the overrun flag |
| overrun | output | 1 | Sticky flag: a character was discarded |
| trig_lvl | input | 7 | Interrupt trigger level |
| hyst | input | 4 | Hysteresis around the trigger for the request output |
| auto_req_en | input | 1 | Enable automatic request-output control |
| auto_clr_en | input | 1 | Enable automatic transmitter gating |
| pair_sel | input | 1 | 0: RTS/CTS pair, 1: DTR/DSR pair |
| man_rts | input | 1 | Manual request-to-send bit (1 drives `rts_n` low) |
| man_dtr | input | 1 | Manual terminal-ready bit (1 drives `dtr_n` low) |
| rts_n | output | 1 | Active-low request-to-send |
| dtr_n | output | 1 | Active-low terminal-ready |
| cts_n | input | 1 | Active-low clear-to-send |
| dsr_n | input | 1 | Active-low set-ready |
| tx_allow | output | 1 | Local transmitter may send |

## Verification
The bench sweeps sixteen combinations of trigger and hysteresis. These include a hysteresis of zero, a lower threshold that would go below zero, and an upper threshold above the capacity. For each one it fills the queue to 64 and drains it to 0, checking the level, the interrupt and both request outputs at every step. An off-by-one comparator would move the pause or resume point by a character. A design without a held state would toggle the output inside the band. The drains compare every byte and flag against the write order, which exposes pointer wrap errors.

Further checks push one character past full and expect the extra character to vanish while the older data stays intact. They read an empty queue and expect the last byte to stay put and the level to stay at 0. They run in single-register mode and toggle it, and they move the clear inputs while each pair is selected, so that listening to the wrong pin or skipping the synchronizer shows up as a wrong `tx_allow`.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int RXF_DATA_W = 8;
  localparam int RXF_ERR_W  = 3;

  typedef struct packed {
    logic [RXF_ERR_W-1:0]  err;
    logic [RXF_DATA_W-1:0] data;
  } rxf_entry_t;
endpackage

// File: rtl/rxf_rst_sync.sv
module rxf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) shift_q <= '0;
    else         shift_q <= shift_d;
  end

  assign srst_n = shift_q[STAGES-1];
endmodule

// File: rtl/rxf_store.sv
module rxf_store
  import rxf_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic             wr_valid,
  input  rxf_entry_t       wr_entry,
  input  logic             rd_en,
  input  logic             stat_rd,
  output rxf_entry_t       head,
  output logic [CNT_W-1:0] count,
  output logic             overrun
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  rxf_entry_t       mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] count_q, count_d;
  logic             ovr_q, ovr_d;
  logic             mode_q;
  rxf_entry_t       last_q, last_d;

  logic [CNT_W-1:0] cap;
  logic             flush, empty, full, do_push, do_pop, drop;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    cap     = fifo_en ? CNT_W'(DEPTH) : CNT_W'(1);
    flush   = (fifo_en != mode_q);
    empty   = (count_q == '0);
    full    = (count_q >= cap);
    do_pop  = rd_en && !empty && !flush;
    do_push = wr_valid && !flush && (!full || do_pop);
    drop    = wr_valid && !flush && !do_push;

    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    count_d  = count_q;
    last_d   = last_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      count_d  = '0;
    end else begin
      if (do_push) wr_ptr_d = ptr_inc(wr_ptr_q);
      if (do_pop) begin
        rd_ptr_d = ptr_inc(rd_ptr_q);
        last_d   = mem[rd_ptr_q];
      end
      if (do_push && !do_pop)      count_d = count_q + 1'b1;
      else if (do_pop && !do_push) count_d = count_q - 1'b1;
    end

    if (drop)         ovr_d = 1'b1;
    else if (stat_rd) ovr_d = 1'b0;
    else              ovr_d = ovr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
      ovr_q    <= 1'b0;
      mode_q   <= 1'b0;
      last_q   <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
      ovr_q    <= ovr_d;
      mode_q   <= fifo_en;
      last_q   <= last_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr_q] <= wr_entry;
  end

  assign head    = empty ? last_q : mem[rd_ptr_q];
  assign count   = count_q;
  assign overrun = ovr_q;

  p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(DEPTH));

  p_single_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && !flush) |-> (count_q <= CNT_W'(1)));

  p_drop_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && full && !rd_en && !flush) |=> (ovr_q && $stable(count_q)));

  p_empty_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_en && !wr_valid && !flush) |=> (count_q == '0 && $stable(head)));
endmodule

// File: rtl/rxf_flow.sv
module rxf_flow #(
  parameter int CNT_W       = 7,
  parameter int TRIG_W      = 7,
  parameter int HYST_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_en,
  input  logic [CNT_W-1:0]  count,
  input  logic [TRIG_W-1:0] trig_lvl,
  input  logic [HYST_W-1:0] hyst,
  input  logic              auto_req_en,
  input  logic              auto_clr_en,
  input  logic              pair_sel,
  input  logic              man_rts,
  input  logic              man_dtr,
  input  logic              cts_n,
  input  logic              dsr_n,
  output logic              rx_irq,
  output logic              rts_n,
  output logic              dtr_n,
  output logic              tx_allow
);
  localparam int BASE_W = (CNT_W > TRIG_W) ? CNT_W : TRIG_W;
  localparam int CMP_W  = ((BASE_W > HYST_W) ? BASE_W : HYST_W) + 1;

  logic [CMP_W-1:0] lvl_x, trig_x, hyst_x, upper, lower;
  logic             req_man, auto_act, hold_q, hold_d;
  logic [1:0]       sync_q [SYNC_STAGES];
  logic             clr_sync;

  always_comb begin
    lvl_x  = CMP_W'(count);
    trig_x = CMP_W'(trig_lvl);
    hyst_x = CMP_W'(hyst);
    upper  = trig_x + hyst_x;
    lower  = (trig_x >= hyst_x) ? (trig_x - hyst_x) : '0;

    req_man  = pair_sel ? man_dtr : man_rts;
    auto_act = auto_req_en && req_man;

    if (!auto_act)            hold_d = 1'b0;
    else if (lvl_x >= upper)  hold_d = 1'b1;
    else if (lvl_x <= lower)  hold_d = 1'b0;
    else                      hold_d = hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_d;
  end

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      logic [1:0] stage_d;
      if (g == 0) begin : g_first
        assign stage_d = {dsr_n, cts_n};
      end else begin : g_rest
        assign stage_d = sync_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= 2'b00;
        else        sync_q[g] <= stage_d;
      end
    end
  endgenerate

  assign clr_sync = pair_sel ? sync_q[SYNC_STAGES-1][1] : sync_q[SYNC_STAGES-1][0];
  assign tx_allow = !(auto_clr_en && clr_sync);
  assign rts_n    = !(man_rts && !(hold_q && !pair_sel));
  assign dtr_n    = !(man_dtr && !(hold_q && pair_sel));
  assign rx_irq   = fifo_en ? ((count != '0) && (lvl_x >= trig_x)) : (count != '0);

  p_pause_point_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_q) |-> ($past(lvl_x) >= $past(upper)));

  p_resume_point_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(hold_q) && $past(auto_act)) |-> ($past(lvl_x) <= $past(lower)));

  p_manual_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(auto_act) |-> !hold_q);

  p_irq_needs_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> (count != '0));
endmodule

// File: rtl/uart_rx_fifo_fc.sv
module uart_rx_fifo_fc
  import rxf_pkg::*;
#(
  parameter int DEPTH       = 64,
  parameter int TRIG_W      = 7,
  parameter int HYST_W      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2,
  localparam int CNT_W      = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fifo_en,
  input  logic                  wr_valid,
  input  logic [RXF_DATA_W-1:0] wr_data,
  input  logic [RXF_ERR_W-1:0]  wr_err,
  input  logic                  rd_en,
  output logic [RXF_DATA_W-1:0] rd_data,
  output logic [RXF_ERR_W-1:0]  rd_err,
  output logic                  rx_ready,
  output logic [CNT_W-1:0]      fill_level,
  output logic                  rx_irq,
  input  logic                  stat_rd,
  output logic                  overrun,
  input  logic [TRIG_W-1:0]     trig_lvl,
  input  logic [HYST_W-1:0]     hyst,
  input  logic                  auto_req_en,
  input  logic                  auto_clr_en,
  input  logic                  pair_sel,
  input  logic                  man_rts,
  input  logic                  man_dtr,
  output logic                  rts_n,
  output logic                  dtr_n,
  input  logic                  cts_n,
  input  logic                  dsr_n,
  output logic                  tx_allow
);
  logic             srst_n;
  rxf_entry_t       in_entry, head;
  logic [CNT_W-1:0] count;

  rxf_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  assign in_entry.data = wr_data;
  assign in_entry.err  = wr_err;

  rxf_store #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
    .clk      (clk),
    .rst_n    (srst_n),
    .fifo_en  (fifo_en),
    .wr_valid (wr_valid),
    .wr_entry (in_entry),
    .rd_en    (rd_en),
    .stat_rd  (stat_rd),
    .head     (head),
    .count    (count),
    .overrun  (overrun)
  );

  rxf_flow #(
    .CNT_W(CNT_W), .TRIG_W(TRIG_W), .HYST_W(HYST_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_flow (
    .clk         (clk),
    .rst_n       (srst_n),
    .fifo_en     (fifo_en),
    .count       (count),
    .trig_lvl    (trig_lvl),
    .hyst        (hyst),
    .auto_req_en (auto_req_en),
    .auto_clr_en (auto_clr_en),
    .pair_sel    (pair_sel),
    .man_rts     (man_rts),
    .man_dtr     (man_dtr),
    .cts_n       (cts_n),
    .dsr_n       (dsr_n),
    .rx_irq      (rx_irq),
    .rts_n       (rts_n),
    .dtr_n       (dtr_n),
    .tx_allow    (tx_allow)
  );

  assign rd_data    = head.data;
  assign rd_err     = head.err;
  assign fill_level = count;
  assign rx_ready   = (count != '0);
endmodule

// File: tb/uart_rx_fifo_fc_bench.sv
`timescale 1ns/1ps
module uart_rx_fifo_fc_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic fifo_en, wr_valid, rd_en, stat_rd;
  logic [7:0] wr_data, rd_data;
  logic [2:0] wr_err, rd_err;
  logic rx_ready, rx_irq, overrun;
  logic [6:0] fill_level, trig_lvl;
  logic [3:0] hyst;
  logic auto_req_en, auto_clr_en, pair_sel, man_rts, man_dtr;
  logic rts_n, dtr_n, cts_n, dsr_n, tx_allow;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  int mlevel;
  bit mhold;
  logic [10:0] expq [64];

  always #2.5 clk = ~clk;

  uart_rx_fifo_fc u_uart_rx_fifo_fc (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .wr_valid(wr_valid),
    .wr_data(wr_data), .wr_err(wr_err), .rd_en(rd_en), .rd_data(rd_data),
    .rd_err(rd_err), .rx_ready(rx_ready), .fill_level(fill_level),
    .rx_irq(rx_irq), .stat_rd(stat_rd), .overrun(overrun),
    .trig_lvl(trig_lvl), .hyst(hyst), .auto_req_en(auto_req_en),
    .auto_clr_en(auto_clr_en), .pair_sel(pair_sel), .man_rts(man_rts),
    .man_dtr(man_dtr), .rts_n(rts_n), .dtr_n(dtr_n), .cts_n(cts_n),
    .dsr_n(dsr_n), .tx_allow(tx_allow)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic [2:0] e);
    wr_data = d; wr_err = e; wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic pop();
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  function automatic bit hold_model(input int lvl, input int up, input int lo, input bit cur);
    if (lvl >= up) return 1'b1;
    if (lvl <= lo) return 1'b0;
    return cur;
  endfunction

  task automatic flow_check(input int up, input int lo);
    mhold = hold_model(mlevel, up, lo, mhold);
    chk("R2", "fill_level", fill_level, mlevel);
    chk("R2", "rx_irq", rx_irq, (mlevel != 0 && mlevel >= trig_lvl) ? 1 : 0);
    if (pair_sel == 1'b0) begin
      chk("R6", "rts_n", rts_n, mhold);
      chk("R8", "dtr_n unselected", dtr_n, 0);
    end else begin
      chk("R6", "dtr_n", dtr_n, mhold);
      chk("R8", "rts_n unselected", rts_n, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int tlist [4] = '{1, 16, 48, 60};
    int hlist [4] = '{0, 3, 8, 15};
    rst_n = 1'b0; fifo_en = 1'b1; wr_valid = 1'b0; rd_en = 1'b0; stat_rd = 1'b0;
    wr_data = '0; wr_err = '0; trig_lvl = 7'd48; hyst = 4'd8;
    auto_req_en = 1'b0; auto_clr_en = 1'b0; pair_sel = 1'b0;
    man_rts = 1'b0; man_dtr = 1'b0; cts_n = 1'b0; dsr_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R10 reset state
    chk("R10", "fill_level", fill_level, 0);
    chk("R10", "rx_ready", rx_ready, 0);
    chk("R10", "rx_irq", rx_irq, 0);
    chk("R10", "overrun", overrun, 0);
    chk("R10", "rd_data", rd_data, 0);
    chk("R10", "tx_allow", tx_allow, 1);
    chk("R7", "rts_n manual off", rts_n, 1);

    // R1 R2 R6 R8 sweep
    for (int ci = 0; ci < 16; ci++) begin
      int up, lo;
      trig_lvl = 7'(tlist[ci / 4]);
      hyst     = 4'(hlist[ci % 4]);
      pair_sel = ci[0];
      man_rts = 1'b1; man_dtr = 1'b1; auto_req_en = 1'b1;
      up = tlist[ci / 4] + hlist[ci % 4];
      lo = (tlist[ci / 4] >= hlist[ci % 4]) ? tlist[ci / 4] - hlist[ci % 4] : 0;
      mlevel = 0; mhold = 1'b0;
      @(negedge clk);
      for (int i = 0; i < 64; i++) begin
        expq[i] = {3'((i + ci) % 8), 8'((i * 37 + ci * 11) & 255)};
        push(expq[i][7:0], expq[i][10:8]);
        mlevel++;
        flow_check(up, lo);
      end
      for (int i = 0; i < 64; i++) begin
        chk("R1", "rd_data order", rd_data, expq[i][7:0]);
        chk("R1", "rd_err order", rd_err, expq[i][10:8]);
        pop();
        mlevel--;
        flow_check(up, lo);
      end
    end

    // R3 overrun
    pair_sel = 1'b0; trig_lvl = 7'd48; hyst = 4'd8;
    for (int i = 0; i < 64; i++) push(8'(i), 3'(i % 8));
    chk("R3", "overrun before", overrun, 0);
    push(8'hEE, 3'd7);
    chk("R3", "level after drop", fill_level, 64);
    chk("R3", "overrun set", overrun, 1);
    for (int i = 0; i < 64; i++) begin
      chk("R3", "data intact", rd_data, i);
      pop();
    end
    chk("R3", "overrun sticky", overrun, 1);
    stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0; @(negedge clk);
    chk("R3", "overrun cleared", overrun, 0);

    // R4 empty read
    chk("R4", "last value", rd_data, 63);
    pop();
    chk("R4", "level stays 0", fill_level, 0);
    chk("R4", "last value after empty pop", rd_data, 63);
    chk("R4", "rx_ready", rx_ready, 0);

    // R5 single-register mode
    fifo_en = 1'b0; repeat (2) @(negedge clk);
    push(8'hA5, 3'd2);
    chk("R5", "level one", fill_level, 1);
    chk("R5", "irq with one", rx_irq, 1);
    push(8'h5A, 3'd1);
    chk("R5", "capacity one", fill_level, 1);
    chk("R5", "overrun at one", overrun, 1);
    chk("R5", "head kept", rd_data, 8'hA5);
    chk("R5", "head flags", rd_err, 2);
    stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0;
    fifo_en = 1'b1; repeat (2) @(negedge clk);
    chk("R5", "flush on mode change", fill_level, 0);

    // R7 manual override
    for (int i = 0; i < 60; i++) push(8'(i), 3'd0);
    auto_req_en = 1'b1; man_rts = 1'b0; @(negedge clk);
    chk("R7", "manual off holds high", rts_n, 1);
    auto_req_en = 1'b0; man_rts = 1'b1; @(negedge clk);
    chk("R7", "auto off follows manual", rts_n, 0);
    man_dtr = 1'b0; @(negedge clk);
    chk("R7", "dtr follows manual", dtr_n, 1);
    auto_req_en = 1'b1; repeat (2) @(negedge clk);
    chk("R6", "auto above band pauses", rts_n, 1);

    // R9 transmit gating
    auto_clr_en = 1'b1; pair_sel = 1'b0; cts_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9", "cts high blocks", tx_allow, 0);
    cts_n = 1'b0; dsr_n = 1'b1;
    @(negedge clk);
    chk("R9", "sync delay", tx_allow, 0);
    repeat (2) @(negedge clk);
    chk("R9", "dsr ignored when unselected", tx_allow, 1);
    pair_sel = 1'b1; repeat (3) @(negedge clk);
    chk("R9", "dsr high blocks", tx_allow, 0);
    auto_clr_en = 1'b0; @(negedge clk);
    chk("R9", "gating disabled", tx_allow, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule